// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block keeps wall-clock time and calendar date as packed BCD bytes: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A single-cycle strobe at the 32.768 kHz reference rate feeds a binary prescaler. The prescaler makes one tick per second, and each tick steps the calendar through all of its carries in one clock. The block corrects month lengths, including February in leap years. Hours run in 24-hour form or in 12-hour form with an AM/PM flag, and the form is selected by a bit inside the hours byte itself. A stop bit in the seconds byte freezes the count.

A host writes any of the seven time bytes through a simple address/data write port. A host write wins over a tick that lands in the same cycle. Reads never touch the live counters. A one-cycle snapshot request copies the whole live set into a shadow bank, and the read port returns shadow bytes, so a multi-byte read stays coherent while time moves on.

Top module: `rtc_bcd_core`

## Requirements
- R1: Seconds and minutes count in packed BCD, with the low digit in bits 3:0. A seconds value of 0x59 wraps to 0x00 and steps the minutes. Minutes wrap from 0x59 to 0x00 and step the hours.
- R2: 2^PRESCALE_BITS reference strobes make exactly one second. A host write to address 0 (seconds) restarts the prescaler, so the next second takes a full period.
- R3: Bit 7 of the seconds byte (address 0) is a stop bit. While it is 1, no time byte changes. Writing it to 0 resumes counting.
- R4: Bit 7 of the hours byte (address 2) at 0 selects 24-hour form, with hours 0x00 to 0x23. Bit 5 is then the tens-of-hours bit for 20 to 23. Rolling 0x23 over to 0x00 advances the date.
- R5: Bit 7 of the hours byte at 1 selects 12-hour form. Bit 5 is then the PM flag (1 = PM) and bits 4:0 hold the hour, sequenced 12, 01 … 11. The flag toggles on the step from 11 to 12. Only the step from PM 11 to AM 12 advances the date.
- R6: The date (address 3) wraps to 0x01 after 0x30 in months 0x04, 0x06, 0x09 and 0x11, and after 0x31 in the other months. The month then advances.
- R7: In month 0x02 the last date is 0x29 when the year value is divisible by 4 (00 counts as leap) and 0x28 otherwise.
- R8: The day of week (address 5) counts 1 to 7, wraps to 1, and advances whenever the date does.
- R9: The month (address 4) wraps from 0x12 to 0x01 and advances the year (address 6). The year wraps from 0x99 to 0x00.
- R10: A one-cycle snap_req copies all seven live bytes into the shadow bank. rd_data returns the shadow byte at rd_addr, which stays unchanged until the next request.
- R11: After reset, the live bytes and the shadow bytes all read 00:00:00 in 24-hour form, running, date 0x01, month 0x01, day of week 0x01, year 0x00.
- R12: Address map: 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 day of week, 6 year. Address 7 reads 0x00. Hours bit 6 is not stored and always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | One-cycle strobe at the reference rate |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Host write address |
| wr_data | input | 8 | Host write byte |
| snap_req | input | 1 | Copy live time into the shadow bank |
| rd_addr | input | 3 | Shadow read address |
| rd_data | output | 8 | Shadow byte at rd_addr |

## Verification
The bench sets the calendar one second before each rollover and checks every carry that follows. It covers the BCD digit carry and New Year's Eve, where every field wraps at once. It also checks February in leap years (including 00 and an odd-tens year such as 92) and in common years, the 30-day months, and the 12-hour PM 11 to AM 12 step, which alone may advance the date. A design with a binary increment, a plain divide-by-4 on the raw byte, or a flag toggled on the wrong hour would show a wrong byte at these points.

Directed tests cover the remaining cases:
- A half-elapsed prescaler that is not cleared by a seconds write would produce an early tick.
- A stop bit that fails to gate the prescaler would let the seconds move.
- A read port wired to the live counters would show time advancing without a snapshot.

// File: rtl/rtc_pkg.sv
// Package: shared types and BCD helpers for the real-time calendar counter.
// Assumes all fields hold valid packed BCD when arithmetic is applied.
package rtc_pkg;

    localparam int NUM_REGS  = 7;
    localparam int ADDR_W    = 3;
    localparam int BYTE_W    = 8;
    localparam int FLAT_W    = NUM_REGS * BYTE_W;

    typedef enum logic [ADDR_W-1:0] {
        A_SEC   = 3'd0,
        A_MIN   = 3'd1,
        A_HOUR  = 3'd2,
        A_DATE  = 3'd3,
        A_MONTH = 3'd4,
        A_DOW   = 3'd5,
        A_YEAR  = 3'd6
    } rtc_addr_e;

    // First member is the most significant byte; seconds sits at byte 0.
    typedef struct packed {
        logic [7:0] year;
        logic [7:0] dow;
        logic [7:0] month;
        logic [7:0] date;
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } rtc_time_t;

    localparam rtc_time_t RTC_RESET = rtc_time_t'(56'h00_01_01_01_00_00_00);

    // Add one to a two-digit packed BCD value (no wrap check).
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Year value divisible by four, tested digit-wise on packed BCD.
    function automatic logic is_leap(input logic [7:0] yr);
        logic [3:0] ones;
        ones = yr[3:0];
        if (!yr[4])
            return (ones == 4'd0) || (ones == 4'd4) || (ones == 4'd8);
        else
            return (ones == 4'd2) || (ones == 4'd6);
    endfunction

    // Last valid date of a month, in packed BCD.
    function automatic logic [7:0] last_day(input logic [7:0] mon, input logic [7:0] yr);
        case (mon)
            8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
// Module: rtc_prescaler
// Divides the reference strobe by 2^PW to a one-cycle second tick.
// Assumes ref_tick is a single-cycle strobe in the clk domain. Counting
// pauses while run is low; clear restarts the period and suppresses a tick.
module rtc_prescaler #(
    parameter int PW = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick,
    input  logic run,
    input  logic clear,
    output logic sec_tick
);

    localparam logic [PW-1:0] CNT_MAX = '1;

    logic [PW-1:0] cnt;

    assign sec_tick = ref_tick && run && !clear && (cnt == CNT_MAX);

    // Advance the divider on each enabled strobe, restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear)
            cnt <= '0;
        else if (ref_tick && run)
            cnt <= cnt + 1'b1;
    end

    // R2: a seconds write leaves the divider at the start of a period.
    p_clear_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt == '0));

    // R3: a stopped clock leaves the divider untouched.
    p_stop_holds_div_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clear) |=> $stable(cnt));

endmodule

// File: rtl/rtc_counters.sv
// Module: rtc_counters
// Holds the live calendar and steps it once per second tick, rippling all
// carries in one clock. A host write replaces one byte and wins over a tick
// in the same cycle. Assumes written values are valid packed BCD.
module rtc_counters
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    output rtc_time_t  live,
    output logic       halted
);

    rtc_time_t cur;
    rtc_time_t nxt;
    logic c_sec, c_min, c_day, c_mon, c_yr, hr_wrap;

    assign live   = cur;
    assign halted = cur.sec[7];

    // Compute the calendar one second later.
    always_comb begin
        nxt     = cur;
        c_min   = 1'b0;
        c_day   = 1'b0;
        c_mon   = 1'b0;
        c_yr    = 1'b0;
        hr_wrap = 1'b0;

        c_sec   = (cur.sec[6:0] == 7'h59);
        nxt.sec = c_sec ? {cur.sec[7], 7'h00}
                        : ((bcd_inc(cur.sec & 8'h7F) & 8'h7F) | (cur.sec & 8'h80));

        if (c_sec) begin
            c_min   = (cur.min == 8'h59);
            nxt.min = c_min ? 8'h00 : bcd_inc(cur.min);
        end

        if (c_sec && c_min) begin
            if (cur.hour[7]) begin
                if (cur.hour[4:0] == 5'h12) begin
                    nxt.hour = {1'b1, 1'b0, cur.hour[5], 5'h01};
                end else if (cur.hour[4:0] == 5'h11) begin
                    nxt.hour = {1'b1, 1'b0, ~cur.hour[5], 5'h12};
                    hr_wrap  = cur.hour[5];
                end else begin
                    nxt.hour = {1'b1, 1'b0, cur.hour[5], 5'h00}
                             | (bcd_inc({3'b000, cur.hour[4:0]}) & 8'h1F);
                end
            end else begin
                hr_wrap  = (cur.hour == 8'h23);
                nxt.hour = hr_wrap ? 8'h00 : bcd_inc(cur.hour);
            end
        end

        c_day = c_sec && c_min && hr_wrap;
        if (c_day) begin
            nxt.dow  = (cur.dow == 8'h07) ? 8'h01 : cur.dow + 8'h01;
            c_mon    = (cur.date == last_day(cur.month, cur.year));
            nxt.date = c_mon ? 8'h01 : bcd_inc(cur.date);
        end

        if (c_mon) begin
            c_yr      = (cur.month == 8'h12);
            nxt.month = c_yr ? 8'h01 : bcd_inc(cur.month);
        end

        if (c_yr)
            nxt.year = (cur.year == 8'h99) ? 8'h00 : bcd_inc(cur.year);
    end

    // Apply a host write, otherwise take the stepped value on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= RTC_RESET;
        end else if (wr_en) begin
            case (wr_addr)
                A_SEC:   cur.sec   <= wr_data;
                A_MIN:   cur.min   <= {1'b0, wr_data[6:0]};
                A_HOUR:  cur.hour  <= {wr_data[7], 1'b0, wr_data[5:0]};
                A_DATE:  cur.date  <= {2'b00, wr_data[5:0]};
                A_MONTH: cur.month <= {3'b000, wr_data[4:0]};
                A_DOW:   cur.dow   <= {5'b00000, wr_data[2:0]};
                A_YEAR:  cur.year  <= wr_data;
                default: ;
            endcase
        end else if (sec_tick) begin
            cur <= nxt;
        end
    end

    // R1: seconds at 59 wrap to 00 and the minutes move.
    p_sec_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !wr_en && cur.sec[6:0] == 7'h59)
        |=> (cur.sec[6:0] == 7'h00) && (cur.min != $past(cur.min)));

    // R3: while the stop bit is set and nobody writes, nothing moves.
    p_stop_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur.sec[7] && !wr_en) |=> $stable(cur));

    // R4: 23:59:59 in 24-hour form goes to hour 00 and a new date.
    p_day_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !wr_en && !cur.hour[7] && cur.hour == 8'h23
         && cur.min == 8'h59 && cur.sec[6:0] == 7'h59)
        |=> (cur.hour == 8'h00) && (cur.date != $past(cur.date)));

    // R8: a day of week inside 1..7 stays inside 1..7 across a tick.
    p_dow_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !wr_en && cur.dow >= 8'h01 && cur.dow <= 8'h07)
        |=> (cur.dow >= 8'h01) && (cur.dow <= 8'h07));

endmodule

// File: rtl/rtc_shadow.sv
// Module: rtc_shadow
// Shadow bank loaded from the live calendar on a snapshot request, plus the
// byte-wide read multiplexer. Assumes snap is a one-cycle request.
module rtc_shadow
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       snap,
    input  rtc_time_t  live,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data
);

    localparam int LANES = 1 << ADDR_W;

    rtc_time_t  shadow;
    logic [7:0] lane [LANES];

    // Capture the whole live set in one cycle on request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow <= RTC_RESET;
        else if (snap)
            shadow <= live;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g < NUM_REGS) begin : g_used
            assign lane[g] = shadow[g*BYTE_W +: BYTE_W];
        end else begin : g_empty
            assign lane[g] = 8'h00;
        end
    end

    assign rd_data = lane[rd_addr];

    // R10: without a request the shadow bank does not move.
    p_shadow_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !snap |=> $stable(shadow));

    // R10: a request captures exactly the live values of that cycle.
    p_shadow_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> (shadow == $past(live)));

endmodule

// File: rtl/rtc_bcd_core.sv
// Module: rtc_bcd_core (top)
// Real-time calendar counter: prescaler, live BCD calendar, shadow read bank.
// Assumes ref_tick is already synchronised to clk as a one-cycle strobe.
module rtc_bcd_core
    import rtc_pkg::*;
#(
    parameter int PRESCALE_BITS = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_tick,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       snap_req,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data
);

    rtc_time_t live;
    logic      halted;
    logic      sec_tick;
    logic      sec_write;

    assign sec_write = wr_en && (wr_addr == A_SEC);

    rtc_prescaler #(.PW(PRESCALE_BITS)) u_prescaler (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .run      (!halted),
        .clear    (sec_write),
        .sec_tick (sec_tick)
    );

    rtc_counters u_counters (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_tick (sec_tick),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .live     (live),
        .halted   (halted)
    );

    rtc_shadow u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .snap     (snap_req),
        .live     (live),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

endmodule

// File: tb/rtc_bcd_core_bench.sv
// Bench for rtc_bcd_core: a rollover vector table, then directed tests.
module rtc_bcd_core_bench;

    localparam int PW  = 2;
    localparam int TPS = 1 << PW;
    localparam int NV  = 16;

    // {start year,dow,month,date,hour,min,sec , expected same order}, one second apart
    localparam logic [111:0] VEC [NV] = '{
        112'h24010101000000_24010101000001, // R1
        112'h24010101000009_24010101000010, // R1
        112'h24010101000759_24010101000800, // R1
        112'h99071231235959_00010101000000, // R9
        112'h24020228235959_24030229000000, // R7
        112'h23020228235959_23030301000000, // R7
        112'h00040229235959_00050301000000, // R7
        112'h92040228235959_92050229000000, // R7
        112'h10040228235959_10050301000000, // R7
        112'h24030430235959_24040501000000, // R6
        112'h24060130235959_24070131000000, // R6
        112'h24010101195959_24010101200000, // R4
        112'h24010101915959_24010101B20000, // R5
        112'h24070115B15959_24010116920000, // R5 R8
        112'h24010101925959_24010101810000, // R5
        112'h24021130235959_24031201000000  // R6
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic       snap_req = 1'b0;
    logic [2:0] rd_addr = 3'd0;
    logic [7:0] rd_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rtc_bcd_core #(.PRESCALE_BITS(PW)) u_rtc_bcd_core (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .snap_req(snap_req), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic string vec_tag(input int i);
        case (i)
            0, 1, 2:                return "R1";
            3:                      return "R9";
            4, 5, 6, 7, 8:          return "R7";
            9, 10, 15:              return "R6";
            11:                     return "R4";
            13:                     return "R5/R8";
            default:                return "R5";
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic strobes(input int n);
        @(negedge clk);
        ref_tick = 1'b1;
        repeat (n) @(negedge clk);
        ref_tick = 1'b0;
    endtask

    task automatic snap();
        @(negedge clk);
        snap_req = 1'b1;
        @(negedge clk);
        snap_req = 1'b0;
    endtask

    task automatic read_reg(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic read_all(output logic [55:0] t);
        logic [7:0] b;
        for (int a = 0; a < 7; a++) begin
            read_reg(3'(a), b);
            t[a*8 +: 8] = b;
        end
    endtask

    task automatic load_all(input logic [55:0] t);
        for (int a = 1; a < 7; a++)
            write_reg(3'(a), t[a*8 +: 8]);
        write_reg(3'd0, t[7:0]);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [55:0] t;
        logic [7:0]  b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset values in the shadow bank, then after a snapshot
        read_all(t);
        check("R11 shadow", 64'(t), 64'(56'h00010101000000));
        snap();
        read_all(t);
        check("R11 live", 64'(t), 64'(56'h00010101000000));

        // Rollover table: each entry is one second of counting
        for (int i = 0; i < NV; i++) begin
            load_all(VEC[i][111:56]);
            strobes(TPS);
            snap();
            read_all(t);
            check(vec_tag(i), 64'(t), 64'(VEC[i][55:0]));
        end

        // R2: seconds write restarts a half-elapsed prescaler
        load_all(56'h24010101000000);
        strobes(TPS / 2);
        write_reg(3'd0, 8'h00);
        strobes(TPS - 1);
        snap();
        read_reg(3'd0, b);
        check("R2 no early tick", 64'(b), 64'h00);
        strobes(1);
        snap();
        read_reg(3'd0, b);
        check("R2 full period", 64'(b), 64'h01);

        // R3: stop bit freezes the count, clearing it resumes
        write_reg(3'd0, 8'hB0);
        strobes(2 * TPS);
        snap();
        read_reg(3'd0, b);
        check("R3 stopped", 64'(b), 64'hB0);
        write_reg(3'd0, 8'h30);
        strobes(TPS);
        snap();
        read_reg(3'd0, b);
        check("R3 resumed", 64'(b), 64'h31);

        // R10: reads hold the captured value until the next request
        write_reg(3'd0, 8'h10);
        snap();
        strobes(TPS);
        read_reg(3'd0, b);
        check("R10 held", 64'(b), 64'h10);
        snap();
        read_reg(3'd0, b);
        check("R10 refreshed", 64'(b), 64'h11);

        // R12: hours bit 6 is dropped, address 7 reads zero
        write_reg(3'd2, 8'h45);
        snap();
        read_reg(3'd2, b);
        check("R12 hour bit6", 64'(b), 64'h05);
        read_reg(3'd7, b);
        check("R12 addr7", 64'(b), 64'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule